// File: doc/BRIEF.md
# Unicast Per-Port Class Queue Manager

This block holds the unicast transmit queues of a switch frame engine. Each queue belongs to one output port and one traffic class. It is a singly linked list of frame handles, and the next-pointer storage is internal, indexed by handle. The default configuration has eight fast ports with two classes each and two high-speed ports with four classes each, which gives 24 queues.

A switch response carries a destination port, a 3-bit transmit priority and a frame handle. The block maps the priority to one of the port's classes. It then decides whether to admit the frame, looking at the global buffer usage and at how full the destination queue is. An admitted handle is linked onto the tail of its queue. A dropped handle is returned on the release outputs.

When a port has room for another frame it raises a dequeue request. The block answers one cycle later with the head-of-line handle of that port's highest non-empty class.

Top module: `uq_mgr`

## Requirements
- R1: On a fast port (port number below 8), the class is priority bit 2, so priorities 0-3 go to class 0 and 4-7 go to class 1.
- R2: On a high-speed port (port 8 or 9), the class is priority bits 2:1, so priorities 0-1 go to class 0, 2-3 to class 1, 4-5 to class 2 and 6-7 to class 3.
- R3: Handles within one queue are dequeued in the order they were admitted.
- R4: A dequeue request for a port returns the head of the highest-numbered non-empty class of that port, and `deq_cls` gives that class number.
- R5: One cycle after a dequeue request, `deq_ack` is high. If every class of the port is empty, `deq_found` is low and `deq_handle` reads 0.
- R6: A response that arrives while `glob_used` is greater than `glob_limit` is dropped and never linked.
- R7: A response whose destination queue already holds Q_LIMIT handles (default 4) is dropped. The queue contents are unchanged.
- R8: A dropped handle appears on `rel_handle`, with `rel_valid` high, in the cycle after the response. An admitted response never raises `rel_valid`.
- R9: A response addressed to a port number of 10 or above is dropped and released.
- R10: An admission and a dequeue may hit the same queue in one cycle, including a queue that holds a single handle. The old head is returned and the new handle remains queued.
- R11: After reset all queues are empty and `rel_valid`, `deq_ack` and `deq_found` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Switch response strobe |
| rsp_port | input | 4 | Destination port |
| rsp_prio | input | 3 | Transmit priority, 0 lowest |
| rsp_handle | input | 6 | Frame handle |
| glob_used | input | 7 | Current global buffer usage |
| glob_limit | input | 7 | Usage above which frames are dropped |
| rel_valid | output | 1 | Dropped handle strobe |
| rel_handle | output | 6 | Handle to release |
| deq_req | input | 1 | Port asks for its next frame |
| deq_port | input | 4 | Requesting port |
| deq_ack | output | 1 | Answer strobe, one cycle after the request |
| deq_found | output | 1 | A handle was returned |
| deq_handle | output | 6 | Head-of-line handle, 0 when none |
| deq_cls | output | 2 | Class the handle was taken from |

## Verification
On every cycle, the assertions check the timing of the answer and of the release strobes. They also check that an over-budget or misaddressed response is released with its own handle, that an empty answer carries handle 0, and that the class returned lies within the requesting port's class count. Priority mapping, FIFO order, strict priority among classes, the queue-full limit and the single-entry simultaneous case all depend on the history of the lists. Only the bench's scenarios show those, by comparing returned handles with values worked out from the port and priority sweep.

// File: rtl/uq_pkg.sv
package uq_pkg;
   // first queue index owned by a port: fast ports first, then high-speed
   function automatic int q_base(input int port, input int nf, input int cf, input int ch);
      if (port < nf) return port * cf;
      return nf * cf + (port - nf) * ch;
   endfunction

   // number of classes a port owns
   function automatic int n_cls(input int port, input int nf, input int cf, input int ch);
      return (port < nf) ? cf : ch;
   endfunction
endpackage

// File: rtl/uq_class_map.sv
module uq_class_map
   import uq_pkg::*;
#(
   parameter int NF = 8,
   parameter int CF = 2,
   parameter int NH = 2,
   parameter int CH = 4,
   parameter int PW = 4,
   parameter int QW = 5,
   parameter int CW = 2
) (
   input  logic [PW-1:0] port,
   input  logic [2:0]    prio,
   output logic          port_ok,
   output logic [QW-1:0] qidx,
   output logic [CW-1:0] cls
);
   localparam int FSH = 3 - $clog2(CF);
   localparam int HSH = 3 - $clog2(CH);

   logic [2:0] c3;

   always_comb begin
      port_ok = int'(port) < (NF + NH);
      if (int'(port) < NF) c3 = prio >> FSH;
      else                 c3 = prio >> HSH;
      cls  = CW'(c3);
      qidx = '0;
      if (port_ok) qidx = QW'(q_base(int'(port), NF, CF, CH) + int'(c3));
   end
endmodule

// File: rtl/uq_admit.sv
module uq_admit #(
   parameter int GW     = 7,
   parameter int CNW    = 3,
   parameter int Q_LIMIT = 4
) (
   input  logic           valid,
   input  logic           port_ok,
   input  logic [GW-1:0]  glob_used,
   input  logic [GW-1:0]  glob_limit,
   input  logic [CNW-1:0] qcnt,
   output logic           accept,
   output logic           drop
);
   logic glob_over;
   logic q_full;

   always_comb begin
      glob_over = glob_used > glob_limit;
      q_full    = int'(qcnt) >= Q_LIMIT;
      accept    = valid && port_ok && !glob_over && !q_full;
      drop      = valid && !accept;
   end
endmodule

// File: rtl/uq_hol_sel.sv
module uq_hol_sel
   import uq_pkg::*;
#(
   parameter int NF = 8,
   parameter int CF = 2,
   parameter int NH = 2,
   parameter int CH = 4,
   parameter int NQ = 24,
   parameter int PW = 4,
   parameter int QW = 5,
   parameter int CW = 2
) (
   input  logic          req,
   input  logic [PW-1:0] port,
   input  logic [NQ-1:0] nonempty,
   output logic          found,
   output logic [QW-1:0] qidx,
   output logic [CW-1:0] cls
);
   always_comb begin
      int b;
      int n;
      found = 1'b0;
      qidx  = '0;
      cls   = '0;
      b     = q_base(int'(port), NF, CF, CH);
      n     = n_cls(int'(port), NF, CF, CH);
      if (req && int'(port) < NF + NH) begin
         // ascending scan: the last hit is the highest class
         for (int c = 0; c < CH; c++) begin
            if (c < n) begin
               if (nonempty[b + c]) begin
                  found = 1'b1;
                  qidx  = QW'(b + c);
                  cls   = CW'(c);
               end
            end
         end
      end
   end
endmodule

// File: rtl/uq_mgr.sv
module uq_mgr #(
   parameter int NF      = 8,
   parameter int CF      = 2,
   parameter int NH      = 2,
   parameter int CH      = 4,
   parameter int HW      = 6,
   parameter int Q_LIMIT = 4,
   localparam int NP  = NF + NH,
   localparam int NQ  = NF * CF + NH * CH,
   localparam int PW  = $clog2(NP + 6),
   localparam int QW  = $clog2(NQ),
   localparam int CW  = $clog2(CH),
   localparam int GW  = HW + 1,
   localparam int CNW = $clog2(Q_LIMIT + 1),
   localparam int NH_ENT = 1 << HW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rsp_valid,
   input  logic [PW-1:0] rsp_port,
   input  logic [2:0]    rsp_prio,
   input  logic [HW-1:0] rsp_handle,
   input  logic [GW-1:0] glob_used,
   input  logic [GW-1:0] glob_limit,
   output logic          rel_valid,
   output logic [HW-1:0] rel_handle,
   input  logic          deq_req,
   input  logic [PW-1:0] deq_port,
   output logic          deq_ack,
   output logic          deq_found,
   output logic [HW-1:0] deq_handle,
   output logic [CW-1:0] deq_cls
);
   // elaboration-time parameter checks
   if (CF < 1 || CF > 8 || (CF & (CF - 1)) != 0)
      $error("CF must be a power of two up to 8");
   if (CH < 2 || CH > 8 || (CH & (CH - 1)) != 0)
      $error("CH must be a power of two from 2 to 8");
   if (CH < CF)
      $error("high-speed ports need at least as many classes as fast ports");
   if (Q_LIMIT < 1)
      $error("Q_LIMIT must be positive");

   logic [HW-1:0]  head [NQ];
   logic [HW-1:0]  tail [NQ];
   logic [CNW-1:0] cnt  [NQ];
   logic [HW-1:0]  nxt  [NH_ENT];
   logic [NQ-1:0]  nonempty;

   logic          port_ok;
   logic [QW-1:0] enq_q;
   logic [CW-1:0] enq_cls;
   logic          accept;
   logic          drop;
   logic          deq_go;
   logic [QW-1:0] deq_q;
   logic [CW-1:0] sel_cls;
   logic [HW-1:0] new_head;

   for (genvar q = 0; q < NQ; q++) begin : g_ne
      assign nonempty[q] = cnt[q] != '0;
   end

   uq_class_map #(.NF(NF), .CF(CF), .NH(NH), .CH(CH), .PW(PW), .QW(QW), .CW(CW)) map_i (
      .port(rsp_port), .prio(rsp_prio), .port_ok(port_ok), .qidx(enq_q), .cls(enq_cls)
   );

   uq_admit #(.GW(GW), .CNW(CNW), .Q_LIMIT(Q_LIMIT)) adm_i (
      .valid(rsp_valid), .port_ok(port_ok), .glob_used(glob_used), .glob_limit(glob_limit),
      .qcnt(cnt[enq_q]), .accept(accept), .drop(drop)
   );

   uq_hol_sel #(.NF(NF), .CF(CF), .NH(NH), .CH(CH), .NQ(NQ), .PW(PW), .QW(QW), .CW(CW)) sel_i (
      .req(deq_req), .port(deq_port), .nonempty(nonempty),
      .found(deq_go), .qidx(deq_q), .cls(sel_cls)
   );

   // successor of the departing head; a single-entry queue that receives
   // a handle in the same cycle takes that handle as its new head
   always_comb begin
      new_head = nxt[head[deq_q]];
      if (cnt[deq_q] == CNW'(1)) begin
         if (accept && enq_q == deq_q) new_head = rsp_handle;
         else                          new_head = head[deq_q];
      end
   end

   always_ff @(posedge clk) begin
      if (accept && cnt[enq_q] != '0)
         nxt[tail[enq_q]] <= rsp_handle;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < NQ; q++) begin
            head[q] <= '0;
            tail[q] <= '0;
            cnt[q]  <= '0;
         end
         rel_valid  <= 1'b0;
         rel_handle <= '0;
         deq_ack    <= 1'b0;
         deq_found  <= 1'b0;
         deq_handle <= '0;
         deq_cls    <= '0;
      end else begin
         for (int q = 0; q < NQ; q++) begin
            if ((accept && enq_q == QW'(q)) && !(deq_go && deq_q == QW'(q)))
               cnt[q] <= cnt[q] + CNW'(1);
            else if (!(accept && enq_q == QW'(q)) && (deq_go && deq_q == QW'(q)))
               cnt[q] <= cnt[q] - CNW'(1);
         end
         if (accept) begin
            tail[enq_q] <= rsp_handle;
            if (cnt[enq_q] == '0) head[enq_q] <= rsp_handle;
         end
         if (deq_go) head[deq_q] <= new_head;

         rel_valid  <= drop;
         rel_handle <= drop ? rsp_handle : '0;
         deq_ack    <= deq_req;
         deq_found  <= deq_go;
         deq_handle <= deq_go ? head[deq_q] : '0;
         deq_cls    <= deq_go ? sel_cls : '0;
      end
   end
endmodule

// File: rtl/uq_mgr_chk.sv
module uq_mgr_chk #(
   parameter int NF = 8,
   parameter int NP = 10,
   parameter int CF = 2,
   parameter int PW = 4,
   parameter int HW = 6,
   parameter int GW = 7,
   parameter int CW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rsp_valid,
   input logic [PW-1:0] rsp_port,
   input logic [2:0]    rsp_prio,
   input logic [HW-1:0] rsp_handle,
   input logic [GW-1:0] glob_used,
   input logic [GW-1:0] glob_limit,
   input logic          rel_valid,
   input logic [HW-1:0] rel_handle,
   input logic          deq_req,
   input logic [PW-1:0] deq_port,
   input logic          deq_ack,
   input logic          deq_found,
   input logic [HW-1:0] deq_handle,
   input logic [CW-1:0] deq_cls
);
   // R8: a release only ever follows a response
   p_rel_after_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> $past(rsp_valid));

   // R6: over-budget responses are released with their own handle
   p_glob_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && glob_used > glob_limit) |=> (rel_valid && rel_handle == $past(rsp_handle)));

   // R9: misaddressed responses are released
   p_bad_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && int'(rsp_port) >= NP) |=> rel_valid);

   // R5: a request is answered in the next cycle
   p_ack_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      deq_req |=> deq_ack);

   // R5: no answer without a request, empty answers carry zero
   p_found_has_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      deq_found |-> deq_ack);
   p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_ack && !deq_found) |-> deq_handle == '0);

   // R1: a fast port never returns a class beyond its count
   p_fast_cls_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_found && int'($past(deq_port)) < NF) |-> int'(deq_cls) < CF);
endmodule

bind uq_mgr uq_mgr_chk #(
   .NF(NF), .NP(NF + NH), .CF(CF), .PW($clog2(NF + NH + 6)), .HW(HW), .GW(HW + 1), .CW($clog2(CH))
) chk_i (.*);

// File: tb/uq_mgr_tb.sv
module uq_mgr_tb_top;
   localparam int PW = 4;
   localparam int HW = 6;
   localparam int GW = 7;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rsp_valid = 1'b0;
   logic [PW-1:0] rsp_port = '0;
   logic [2:0]    rsp_prio = '0;
   logic [HW-1:0] rsp_handle = '0;
   logic [GW-1:0] glob_used = '0;
   logic [GW-1:0] glob_limit = GW'(100);
   logic          rel_valid;
   logic [HW-1:0] rel_handle;
   logic          deq_req = 1'b0;
   logic [PW-1:0] deq_port = '0;
   logic          deq_ack;
   logic          deq_found;
   logic [HW-1:0] deq_handle;
   logic [CW-1:0] deq_cls;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uq_mgr dut_i (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive a response; the release outputs show up one cycle later
   task automatic send(input int port, input int prio, input int h, input bit exp_rel, input string tag);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_port = PW'(port); rsp_prio = 3'(prio); rsp_handle = HW'(h);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk(rel_valid == exp_rel, tag, int'(rel_valid), int'(exp_rel));
      if (exp_rel) chk(int'(rel_handle) == h, tag, int'(rel_handle), h);
   endtask

   task automatic pull(input int port, input bit exp_f, input int exp_h, input int exp_c, input string tag);
      @(negedge clk);
      deq_req = 1'b1; deq_port = PW'(port);
      @(negedge clk);
      deq_req = 1'b0;
      chk(deq_ack && deq_found == exp_f, tag, int'(deq_found), int'(exp_f));
      chk(int'(deq_handle) == exp_h, tag, int'(deq_handle), exp_h);
      if (exp_f) chk(int'(deq_cls) == exp_c, tag, int'(deq_cls), exp_c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!rel_valid && !deq_ack && !deq_found, "R11 reset outputs", int'(rel_valid), 0);
      rst_n = 1'b1;
      pull(0, 0, 0, 0, "R11 empty after reset");

      // R1/R2: sweep every port and priority, one handle at a time
      for (int p = 0; p < 10; p++) begin
         for (int pr = 0; pr < 8; pr++) begin
            int h;
            int c;
            h = (p * 8 + pr) % 64;
            c = (p < 8) ? (pr >> 2) : (pr >> 1);
            send(p, pr, h, 0, "R8 accepted no release");
            pull(p, 1, h, c, (p < 8) ? "R1 fast class" : "R2 hs class");
            pull(p, 0, 0, 0, "R5 empty answer");
         end
      end

      // R3: FIFO order
      send(3, 1, 10, 0, "R3 enq"); send(3, 2, 11, 0, "R3 enq"); send(3, 0, 12, 0, "R3 enq");
      pull(3, 1, 10, 0, "R3 order"); pull(3, 1, 11, 0, "R3 order"); pull(3, 1, 12, 0, "R3 order");

      // R4: strict priority on a high-speed port
      send(8, 0, 20, 0, "R4 enq"); send(8, 7, 21, 0, "R4 enq");
      send(8, 3, 22, 0, "R4 enq"); send(8, 5, 23, 0, "R4 enq");
      pull(8, 1, 21, 3, "R4 strict"); pull(8, 1, 23, 2, "R4 strict");
      pull(8, 1, 22, 1, "R4 strict"); pull(8, 1, 20, 0, "R4 strict");
      // R4 on a fast port
      send(6, 1, 24, 0, "R4 enq"); send(6, 6, 25, 0, "R4 enq");
      pull(6, 1, 25, 1, "R4 fast strict"); pull(6, 1, 24, 0, "R4 fast strict");

      // R7: queue full drop
      for (int i = 0; i < 4; i++) send(2, 7, 30 + i, 0, "R7 fill");
      send(2, 4, 34, 1, "R7 full drop");
      for (int i = 0; i < 4; i++) pull(2, 1, 30 + i, 1, "R7 contents kept");
      pull(2, 0, 0, 0, "R7 drained");

      // R6: global budget drop
      glob_used = GW'(101);
      send(1, 5, 40, 1, "R6 global drop");
      glob_used = GW'(100);
      send(1, 5, 41, 0, "R6 at limit accepted");
      pull(1, 1, 41, 1, "R6 only accepted handle");
      pull(1, 0, 0, 0, "R6 dropped not linked");

      // R9: out-of-range port
      send(12, 2, 42, 1, "R9 bad port");

      // R10: simultaneous admit and dequeue on a single-entry queue
      send(5, 6, 50, 0, "R10 enq");
      @(negedge clk);
      rsp_valid = 1'b1; rsp_port = PW'(5); rsp_prio = 3'(6); rsp_handle = HW'(51);
      deq_req = 1'b1; deq_port = PW'(5);
      @(negedge clk);
      rsp_valid = 1'b0; deq_req = 1'b0;
      chk(deq_found && int'(deq_handle) == 50, "R10 old head", int'(deq_handle), 50);
      chk(!rel_valid, "R10 no release", int'(rel_valid), 0);
      pull(5, 1, 51, 1, "R10 new handle kept");
      pull(5, 0, 0, 0, "R10 drained");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule